// File: doc/BRIEF.md
# Asynchronous serial receive framer with break handling

This block turns an asynchronous serial line into character words for a downstream receive buffer. A free-running enable pulses at sixteen times the bit rate and paces the block. The block waits for a falling edge on the line and confirms the start bit at its centre. It then samples each data bit, the optional parity bit and the stop bit at their centres. Each finished character goes out as one word in a single-cycle valid pulse. The word carries the data and three flags: parity error, framing error and break.

The framer tells a damaged character apart from a break. A low stop bit with any non-zero data or parity bit is reported as a framing error. A frame that is low from start to stop is reported as a break. After a framing error, a line that stays low for half a bit is taken as the start of a new character. A break that begins in the middle of a character therefore produces two words: the damaged character first, then the break character. After a break, the line must be high for half a bit before the block looks for another start bit. A one-cycle pulse marks every accepted start bit, so the buffer logic can time overrun and flow-control events to it.

Top module: `async_rx_framer`

## Requirements
- R1: After a falling edge on the synchronized line, a start bit is accepted only if the line is still low at the 8th oversample tick. Acceptance raises `start_pulse` for one clock. A shorter low pulse produces neither a start pulse nor a word.
- R2: `data_len` selects 5, 6, 7 or 8 data bits (codes 0 to 3). Bits arrive LSB first and are sampled every 16 ticks. Data bits above the selected length read as zero.
- R3: `par_mode` codes: 0 none, 1 even, 2 odd, 3 forced one. With parity enabled, one parity bit follows the data. If it differs from the expected value, `word_par_err` is set. In even mode the expected bit is the XOR of the data bits, in odd mode it is the inverse of that XOR, and in forced mode it is always 1.
- R4: A character with a high stop bit produces exactly one word with `word_frm_err` and `word_brk` clear.
- R5: If the stop bit is low but some data or parity bit is high, the word carries the received data with `word_frm_err` set and `word_brk` clear.
- R6: If the stop bit, all data bits and the parity bit are low, the word has data 0, `word_brk` set, and both `word_frm_err` and `word_par_err` clear.
- R7: After a framing error, a line that stays low for 8 ticks after the stop sample counts as a new start edge. That start is confirmed 8 ticks later, and a following character is received normally.
- R8: After a framing error, a line that goes high within those 8 ticks returns the block to idle. The next character is then found by its own falling edge.
- R9: After a break word, the line must be high for 8 consecutive ticks before the block looks for a start edge again. A low pulse before that produces no start.
- R10: A break that starts mid-character gives a framing-error word, then a break word, but only if the line stays low through the whole next character. If the line goes high during the half-bit window after the stop sample, only the framing-error word appears.
- R11: After reset, `word_valid` and `start_pulse` are low. `word_valid` lasts one clock and never coincides with `start_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversample enable, 16 per bit time |
| rxd | input | 1 | Asynchronous serial line, idle high |
| data_len | input | 2 | Data length code: 0..3 selects 5..8 bits |
| par_mode | input | 2 | Parity code: 0 none, 1 even, 2 odd, 3 forced one |
| start_pulse | output | 1 | One-clock pulse on an accepted start bit |
| word_valid | output | 1 | One-clock pulse when a word is presented |
| word_data | output | 8 | Received data, LSB is the first bit on the line |
| word_par_err | output | 1 | Parity mismatch flag for the word |
| word_frm_err | output | 1 | Framing error flag for the word |
| word_brk | output | 1 | Break flag for the word |

## Verification
Random characters over every length and parity code, with some parity bits flipped and some stop bits forced low, separate clean words from parity, framing and break outcomes. Directed line shapes then cover the cases where the line history decides the result. A glitch too short to be a start bit is one. A low stop bit followed by either a continued low or an early rise tells a restart from a return to idle. A low pulse inside the post-break high window must not start a character. Two mid-character breaks of different length show whether the follow-on break word appears only when the line stays low long enough.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int MAX_BITS = 8;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_MARK = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_POST,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                par_err;
        logic                frm_err;
        logic                brk;
    } rx_word_t;

    // Value the parity bit must carry for the given data and mode.
    function automatic logic par_expect(logic [MAX_BITS-1:0] d, par_mode_e m);
        case (m)
            PAR_EVEN: return ^d;
            PAR_ODD:  return ~(^d);
            PAR_MARK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic line,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
            prev <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], rx_in};
            prev <= pipe[STAGES-1];
        end
    end

    assign line = pipe[STAGES-1];
    assign fall = prev & ~line;
endmodule

// File: rtl/srx_judge.sv
module srx_judge
    import srx_pkg::*;
(
    input  logic [MAX_BITS-1:0] data,
    input  logic                par_bit,
    input  logic                stop_bit,
    input  par_mode_e           mode,
    output rx_word_t            word
);
    logic frame_zero;

    always_comb begin
        frame_zero   = (data == '0) && !par_bit && !stop_bit;
        word.data    = data;
        word.brk     = frame_zero;
        word.frm_err = !stop_bit && !frame_zero;
        word.par_err = (mode != PAR_NONE) && !frame_zero &&
                       (par_bit != par_expect(data, mode));
    end
endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                line,
    input  logic                fall,
    input  logic [2:0]          last_idx,
    input  logic                par_en,
    input  rx_word_t            judged,
    output logic [MAX_BITS-1:0] cap_data,
    output logic                cap_par,
    output logic                start_pulse,
    output logic                word_valid,
    output rx_word_t            word_q
);
    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;
    localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
    localparam logic [CW-1:0] FULL_END = CW'(OSR - 1);

    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            bit_idx     <= '0;
            cap_data    <= '0;
            cap_par     <= 1'b0;
            start_pulse <= 1'b0;
            word_valid  <= 1'b0;
            word_q      <= '0;
        end else begin
            start_pulse <= 1'b0;
            word_valid  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (fall) state <= ST_START;
                end
                ST_START: if (tick) begin
                    if (cnt == HALF_END) begin
                        cnt <= '0;
                        if (!line) begin
                            state       <= ST_DATA;
                            start_pulse <= 1'b1;
                            cap_data    <= '0;
                            cap_par     <= 1'b0;
                            bit_idx     <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else cnt <= cnt + 1'b1;
                end
                ST_DATA: if (tick) begin
                    if (cnt == FULL_END) begin
                        cnt               <= '0;
                        cap_data[bit_idx] <= line;
                        if (bit_idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
                        else                     bit_idx <= bit_idx + 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                ST_PAR: if (tick) begin
                    if (cnt == FULL_END) begin
                        cnt     <= '0;
                        cap_par <= line;
                        state   <= ST_STOP;
                    end else cnt <= cnt + 1'b1;
                end
                ST_STOP: if (tick) begin
                    if (cnt == FULL_END) begin
                        cnt        <= '0;
                        word_q     <= judged;
                        word_valid <= 1'b1;
                        if (line)            state <= ST_IDLE;
                        else if (judged.brk) state <= ST_HOLD;
                        else                 state <= ST_POST;
                    end else cnt <= cnt + 1'b1;
                end
                ST_POST: if (tick) begin
                    if (line) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else if (cnt == HALF_END) begin
                        cnt   <= '0;
                        state <= ST_START;
                    end else cnt <= cnt + 1'b1;
                end
                ST_HOLD: if (tick) begin
                    if (!line) cnt <= '0;
                    else if (cnt == HALF_END) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else cnt <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a start is only accepted on a low line sample
    a_r1_start_on_low: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> !$past(line));

    // R7: restart out of the post-stop window only with the line low
    a_r7_restart_low: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && $past(state) == ST_POST) |-> !$past(line));

    // R9: leaving the post-break wait requires a high line
    a_r9_hold_exit_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && $past(state) == ST_HOLD) |-> $past(line));

    // R6: a break word is all zero and carries no other flag
    a_r6_brk_clean: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word_q.brk) |-> (word_q.data == '0 && !word_q.frm_err && !word_q.par_err));

    // R11: valid is a single-cycle pulse
    a_r11_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R11: start and word pulses never coincide
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(start_pulse && word_valid));
endmodule

// File: rtl/async_rx_framer.sv
module async_rx_framer
    import srx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] data_len,
    input  logic [1:0] par_mode,
    output logic       start_pulse,
    output logic       word_valid,
    output logic [7:0] word_data,
    output logic       word_par_err,
    output logic       word_frm_err,
    output logic       word_brk
);
    logic                line, fall;
    logic [MAX_BITS-1:0] cap_data;
    logic                cap_par;
    rx_word_t            judged, word_q;
    par_mode_e           mode;
    logic [2:0]          last_idx;

    assign mode     = par_mode_e'(par_mode);
    assign last_idx = {1'b0, data_len} + 3'd4;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rxd),
        .line  (line),
        .fall  (fall)
    );

    srx_judge u_judge (
        .data     (cap_data),
        .par_bit  (cap_par),
        .stop_bit (line),
        .mode     (mode),
        .word     (judged)
    );

    srx_fsm #(.OSR(OSR)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .line        (line),
        .fall        (fall),
        .last_idx    (last_idx),
        .par_en      (mode != PAR_NONE),
        .judged      (judged),
        .cap_data    (cap_data),
        .cap_par     (cap_par),
        .start_pulse (start_pulse),
        .word_valid  (word_valid),
        .word_q      (word_q)
    );

    assign word_data    = word_q.data;
    assign word_par_err = word_q.par_err;
    assign word_frm_err = word_q.frm_err;
    assign word_brk     = word_q.brk;
endmodule

// File: tb/test_async_rx_framer.sv
module test_async_rx_framer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] data_len = 2'd3;
    logic [1:0] par_mode = 2'd0;
    logic       start_pulse, word_valid, word_par_err, word_frm_err, word_brk;
    logic [7:0] word_data;

    int vectors = 0;
    int fails   = 0;
    int wr      = 0;
    int starts  = 0;
    bit done    = 1'b0;
    logic [10:0] cap [0:511];
    logic [1:0]  tdiv = 2'd0;

    async_rx_framer i_async_rx_framer (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
        .data_len(data_len), .par_mode(par_mode),
        .start_pulse(start_pulse), .word_valid(word_valid),
        .word_data(word_data), .word_par_err(word_par_err),
        .word_frm_err(word_frm_err), .word_brk(word_brk)
    );

    always #5 clk = ~clk;

    // oversample enable: one clock in four
    always @(negedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd3);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (word_valid) begin
                cap[wr] = {word_data, word_par_err, word_frm_err, word_brk};
                wr = wr + 1;
            end
            if (start_pulse) starts = starts + 1;
        end
    end

    function automatic logic par_of(logic [7:0] d, logic [1:0] pm);
        case (pm)
            2'd1:    return ^d;
            2'd2:    return ~(^d);
            2'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // expected word {data, par_err, frm_err, brk}
    function automatic logic [10:0] exp_word(logic [7:0] d, logic [1:0] pm, logic pb, logic stopv);
        logic zero;
        zero = (d == 8'd0) && (pm == 2'd0 || pb == 1'b0) && !stopv;
        if (zero) return {8'd0, 1'b0, 1'b0, 1'b1};
        return {d, (pm != 2'd0) && (pb != par_of(d, pm)), !stopv, 1'b0};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(int n);
        repeat (n) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic hold(logic v, int n);
        rxd = v;
        wait_ticks(n);
    endtask

    task automatic send_char(logic [7:0] d, int nb, logic [1:0] pm, logic pb, logic stopv, int st);
        hold(1'b0, 16);
        for (int i = 0; i < nb; i++) hold(d[i], 16);
        if (pm != 2'd0) hold(pb, 16);
        hold(stopv, st);
        rxd = 1'b1;
    endtask

    task automatic expect_one(string req, int base, int sbase, logic [10:0] exp);
        check(wr == base + 1, req, wr - base, 1);
        check(cap[base] == exp, req, cap[base], exp);
        check(starts == sbase + 1, req, starts - sbase, 1);
    endtask

    task automatic run_char(string req, logic [7:0] d, int nb, logic [1:0] pm, bit flip, logic stopv);
        int base, sbase;
        logic [7:0] dm;
        logic pb;
        base = wr; sbase = starts;
        dm = d & ((8'd1 << nb) - 8'd1);
        pb = (pm == 2'd0) ? 1'b0 : (par_of(dm, pm) ^ flip);
        data_len = 2'(nb - 5);
        par_mode = pm;
        send_char(d, nb, pm, pb, stopv, stopv ? 16 : 12);
        hold(1'b1, 24);
        expect_one(req, base, sbase, exp_word(dm, pm, pb, stopv));
    endtask

    initial begin
        int base, sbase;
        void'($urandom(32'd20240917));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        check(word_valid == 1'b0, "R11 reset valid", word_valid, 0);
        check(start_pulse == 1'b0, "R11 reset start", start_pulse, 0);
        hold(1'b1, 20);
        check(wr == 0, "R11 idle no word", wr, 0);

        // R1 short low glitch rejected
        hold(1'b0, 3); hold(1'b1, 40);
        check(starts == 0, "R1 glitch start", starts, 0);
        check(wr == 0, "R1 glitch word", wr, 0);

        // R4 / R2 directed
        run_char("R4 8N1 clean", 8'hA5, 8, 2'd0, 1'b0, 1'b1);
        run_char("R2 5-bit upper zero", 8'hFF, 5, 2'd0, 1'b0, 1'b1);
        run_char("R2 6-bit", 8'h2D, 6, 2'd0, 1'b0, 1'b1);
        // R3 parity modes
        run_char("R3 even flipped", 8'h37, 8, 2'd1, 1'b1, 1'b1);
        run_char("R3 odd good", 8'h37, 7, 2'd2, 1'b0, 1'b1);
        run_char("R3 forced flipped", 8'h11, 8, 2'd3, 1'b1, 1'b1);
        // R5 framing error, line rises early (R8 too)
        run_char("R5 framing", 8'h3C, 8, 2'd0, 1'b0, 1'b0);

        // R6 break, odd parity still low
        base = wr; sbase = starts;
        data_len = 2'd3; par_mode = 2'd2;
        hold(1'b0, 11 * 16); hold(1'b1, 24);
        expect_one("R6 break", base, sbase, {8'd0, 1'b0, 1'b0, 1'b1});

        // R7 restart after framing error, line stays low into a new start
        base = wr; sbase = starts;
        par_mode = 2'd0;
        send_char(8'h3C, 8, 2'd0, 1'b0, 1'b0, 16);
        send_char(8'hA5, 8, 2'd0, 1'b0, 1'b1, 16);
        hold(1'b1, 24);
        check(wr == base + 2, "R7 two words", wr - base, 2);
        check(cap[base] == {8'h3C, 3'b010}, "R7 first framing", cap[base], {8'h3C, 3'b010});
        check(cap[base+1] == {8'hA5, 3'b000}, "R7 restarted char", cap[base+1], {8'hA5, 3'b000});
        check(starts == sbase + 2, "R7 starts", starts - sbase, 2);

        // R8 early rise after framing error then a normal char
        base = wr;
        send_char(8'h81, 8, 2'd0, 1'b0, 1'b0, 12);
        hold(1'b1, 24);
        send_char(8'h42, 8, 2'd0, 1'b0, 1'b1, 16);
        hold(1'b1, 24);
        check(wr == base + 2, "R8 words", wr - base, 2);
        check(cap[base+1] == {8'h42, 3'b000}, "R8 next char", cap[base+1], {8'h42, 3'b000});

        // R9 low pulse inside post-break high window ignored
        base = wr; sbase = starts;
        hold(1'b0, 10 * 16 + 16); hold(1'b1, 4); hold(1'b0, 20); hold(1'b1, 64);
        check(wr == base + 1, "R9 only break word", wr - base, 1);
        check(starts == sbase + 1, "R9 no extra start", starts - sbase, 1);
        check(cap[base] == 11'b001, "R9 break word", cap[base], 11'b001);
        run_char("R9 hunting resumes", 8'h5A, 8, 2'd0, 1'b0, 1'b1);

        // R10 mid-character break held long: framing word then break word
        base = wr; sbase = starts;
        hold(1'b0, 16); hold(1'b1, 16); hold(1'b0, 16); hold(1'b1, 16);
        hold(1'b0, 40 * 16); hold(1'b1, 32);
        check(wr == base + 2, "R10 long break words", wr - base, 2);
        check(cap[base] == {8'h05, 3'b010}, "R10 damaged char", cap[base], {8'h05, 3'b010});
        check(cap[base+1] == 11'b001, "R10 break char", cap[base+1], 11'b001);
        check(starts == sbase + 2, "R10 starts", starts - sbase, 2);

        // R10 mid-character break ending in the half-bit window
        base = wr; sbase = starts;
        hold(1'b0, 16); hold(1'b1, 16); hold(1'b0, 16); hold(1'b1, 16);
        hold(1'b0, 92); hold(1'b1, 40);
        check(wr == base + 1, "R10 short break words", wr - base, 1);
        check(cap[base] == {8'h05, 3'b010}, "R10 short damaged", cap[base], {8'h05, 3'b010});
        check(starts == sbase + 1, "R10 short starts", starts - sbase, 1);

        // random characters over R2..R6
        for (int k = 0; k < 100; k++) begin
            int nb;
            logic [7:0] d;
            nb = 5 + int'($urandom % 4);
            d  = 8'($urandom);
            if ($urandom % 8 == 0) d = 8'd0;
            run_char("R2-R6 random", d, nb, 2'($urandom % 4), ($urandom % 5) == 0, ($urandom % 6) != 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule